// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with APB Register Access

The block is a down-counting watchdog timer that sits on an APB bus as a slave. It does not count clock cycles directly. An external divider supplies a one-cycle strobe, `tick_en`, and the count falls by one on each strobe. The enable bit in the control register does two jobs: it lets the counter run, and it unmasks the interrupt. Setting the enable bit from zero restarts the count from the reload register.

When the count reaches zero, the raw interrupt flag is set and the count stays at zero until the next tick. On that tick it reloads. Software acknowledges the interrupt by writing to the acknowledge register, which also restarts the count. If the count expires a second time while the flag is still set and the reset enable bit is on, the block drives a one-cycle reset request.

A key register guards all the other writable registers against stray writes. A build parameter selects a sticky variant in which the enable bit cannot be cleared once it is set, except by reset.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the reload register (offset 0x00) and the count register (offset 0x04) read 0xFFFFFFFF. The control register (offset 0x08), the raw status (offset 0x10), the masked status (offset 0x14) and the key register (offset 0xC00) all read 0.
- R2: The count falls by exactly one on each cycle with `tick_en` high, but only while control bit 0 (enable) is 1. While enable is 0, the count holds its value.
- R3: A write to the reload register stores the data there and copies it into the count in the same access, whether or not the counter is enabled.
- R4: A tick that takes the count from 1 to 0 sets raw status bit 0. The count then reads 0 until the next tick, and on that tick it reloads from the reload register.
- R5: A write of any data to the acknowledge register (offset 0x0C) clears raw status bit 0 and reloads the count from the reload register in the same access.
- R6: A control write that changes enable from 0 to 1 reloads the count from the reload register. Clearing enable freezes both the count and the raw status.
- R7: Masked status bit 0 equals raw status bit 0 ANDed with enable, and `irq_o` follows that value.
- R8: Control bit 1 is the reset enable. When it is set and an expiry (a tick from 1 to 0) occurs while raw status is already 1, `rst_req_o` is high for exactly one cycle, starting in the first cycle in which the count reads 0.
- R9: Writing 0x1ACCE551 to the key register unlocks the registers, and writing any other value locks them. The key register reads 1 when locked and 0 when unlocked. While locked, writes to every register except the key register are ignored.
- R10: With `STICKY_EN` = 1, once enable is 1 all control writes are ignored. Control then reads back with bit 0 set, and counting continues until reset. With `STICKY_EN` = 0, control writes always take effect.
- R11: The bus has no wait states (`pready` = 1) and `pslverr` stays 0. A read of any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count strobe from the external divider |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write, 1 for a write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The main test drives two instances, one plain and one sticky, with the same bus traffic and the same tick stream. That makes every control write a direct contrast between the two variants: the sticky copy must keep counting and keep raising interrupts where the plain copy freezes. The tick stream first strobes every cycle and later every third cycle, which separates counting by strobe from counting by clock. A short reload value lets two expiries occur before an acknowledge, so the reset request can be told apart from the first interrupt. Writes made while locked and the reset applied in mid-count show that state is kept or restored exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_RELOAD = 12'h000;
  localparam logic [OFS_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h008;
  localparam logic [OFS_W-1:0] OFS_ACK    = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_RAW    = 12'h010;
  localparam logic [OFS_W-1:0] OFS_MASKED = 12'h014;
  localparam logic [OFS_W-1:0] OFS_KEY    = 12'hC00;

  localparam logic [31:0] KEY_MAGIC = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic en;
  } wdt_ctrl_t;

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter bit          STICKY_EN = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     load_q,
  output wdt_pkg::wdt_ctrl_t    ctrl_q,
  output logic                  locked_q,
  output logic                  ld_wr,
  output logic                  clr_wr,
  output logic                  en_rise
);
  import wdt_pkg::*;

  logic acc_wr, key_hit, wr_ok, ctrl_wr_raw, ctrl_wr;

  function automatic logic addr_is(input logic [ADDR_W-1:0] a,
                                   input logic [OFS_W-1:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign acc_wr      = psel & penable & pwrite;
  assign key_hit     = addr_is(paddr, OFS_KEY);
  assign wr_ok       = acc_wr & ~locked_q & ~key_hit;
  assign ld_wr       = wr_ok & addr_is(paddr, OFS_RELOAD);
  assign clr_wr      = wr_ok & addr_is(paddr, OFS_ACK);
  assign ctrl_wr_raw = wr_ok & addr_is(paddr, OFS_CTRL);

  generate
    if (STICKY_EN) begin : g_sticky
      assign ctrl_wr = ctrl_wr_raw & ~ctrl_q.en;
    end else begin : g_plain
      assign ctrl_wr = ctrl_wr_raw;
    end
  endgenerate

  assign en_rise = ctrl_wr & pwdata[0] & ~ctrl_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (ld_wr) load_q <= pwdata;
      if (ctrl_wr) begin
        ctrl_q.en     <= pwdata[0];
        ctrl_q.rst_en <= pwdata[1];
      end
      if (acc_wr && key_hit) locked_q <= (pwdata != DATA_W'(KEY_MAGIC));
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              en,
  input  logic              rst_en,
  input  logic [DATA_W-1:0] load_q,
  input  logic              ld_wr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr_wr,
  input  logic              en_rise,
  output logic [DATA_W-1:0] value_q,
  output logic              raw_q,
  output logic              rst_pulse_q,
  output logic              expire_evt
);

  logic step;

  function automatic logic at_last(input logic [DATA_W-1:0] v);
    return v == DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] v,
                                                   input logic [DATA_W-1:0] rl);
    return (v == '0) ? rl : v - DATA_W'(1);
  endfunction

  assign step       = en & tick_en & ~ld_wr & ~clr_wr & ~en_rise;
  assign expire_evt = step & at_last(value_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q     <= '1;
      raw_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      if (ld_wr)                 value_q <= ld_data;
      else if (clr_wr | en_rise) value_q <= load_q;
      else if (step)             value_q <= next_count(value_q, load_q);

      if (clr_wr)          raw_q <= 1'b0;
      else if (expire_evt) raw_q <= 1'b1;

      rst_pulse_q <= expire_evt & raw_q & rst_en;
    end
  end

endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  load_q,
  input  logic [DATA_W-1:0]  value_q,
  input  wdt_pkg::wdt_ctrl_t ctrl_q,
  input  logic               raw_q,
  input  logic               locked_q,
  output logic [DATA_W-1:0]  prdata
);
  import wdt_pkg::*;

  always_comb begin
    prdata = '0;
    if      (paddr == ADDR_W'(OFS_RELOAD)) prdata = load_q;
    else if (paddr == ADDR_W'(OFS_COUNT))  prdata = value_q;
    else if (paddr == ADDR_W'(OFS_CTRL))   prdata = DATA_W'({ctrl_q.rst_en, ctrl_q.en});
    else if (paddr == ADDR_W'(OFS_RAW))    prdata = DATA_W'(raw_q);
    else if (paddr == ADDR_W'(OFS_MASKED)) prdata = DATA_W'(raw_q & ctrl_q.en);
    else if (paddr == ADDR_W'(OFS_KEY))    prdata = DATA_W'(locked_q);
  end

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter bit          STICKY_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o,
  output logic              rst_req_o
);

  logic [DATA_W-1:0]  load_q;
  logic [DATA_W-1:0]  value_q;
  wdt_pkg::wdt_ctrl_t ctrl_q;
  logic               locked_q;
  logic               ld_wr, clr_wr, en_rise;
  logic               raw_q, expire_evt;
  logic               en, rst_en;

  assign en     = ctrl_q.en;
  assign rst_en = ctrl_q.rst_en;

  wdt_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STICKY_EN(STICKY_EN)) u_regif (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .load_q(load_q), .ctrl_q(ctrl_q),
    .locked_q(locked_q), .ld_wr(ld_wr), .clr_wr(clr_wr), .en_rise(en_rise)
  );

  wdt_counter #(.DATA_W(DATA_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .en(en), .rst_en(rst_en),
    .load_q(load_q), .ld_wr(ld_wr), .ld_data(pwdata), .clr_wr(clr_wr),
    .en_rise(en_rise), .value_q(value_q), .raw_q(raw_q),
    .rst_pulse_q(rst_req_o), .expire_evt(expire_evt)
  );

  wdt_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .paddr(paddr), .load_q(load_q), .value_q(value_q), .ctrl_q(ctrl_q),
    .raw_q(raw_q), .locked_q(locked_q), .prdata(prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_o   = raw_q & en;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter bit          STICKY_EN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              en,
  input logic              rst_en,
  input logic              locked_q,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] value_q,
  input logic              raw_q,
  input logic              ld_wr,
  input logic              clr_wr,
  input logic              en_rise,
  input logic              expire_evt,
  input logic              irq_o,
  input logic              rst_req_o
);
  import wdt_pkg::*;

  logic quiet;
  assign quiet = !ld_wr && !clr_wr && !en_rise;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && quiet) |=> $stable(value_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_en && quiet && value_q > DATA_W'(1)) |=> value_q == $past(value_q) - DATA_W'(1));

  p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (value_q == $past(pwdata)) && (load_q == $past(pwdata)));

  p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> raw_q && (value_q == '0));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_en && quiet && value_q == '0) |=> value_q == $past(load_q));

  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !raw_q && (value_q == $past(load_q)));

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> en && (value_q == $past(load_q)));

  p_rawfreeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_wr) |=> $stable(raw_q));

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en && raw_q));

  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> ($past(raw_q) && $past(rst_en) && value_q == '0));

  p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && psel && penable && pwrite && paddr != ADDR_W'(OFS_KEY))
      |=> $stable(load_q) && $stable(en) && $stable(rst_en));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (STICKY_EN && en) |=> en);

endmodule

bind tick_watchdog wdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STICKY_EN(STICKY_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .en(en), .rst_en(rst_en),
  .locked_q(locked_q), .load_q(load_q), .value_q(value_q), .raw_q(raw_q),
  .ld_wr(ld_wr), .clr_wr(clr_wr), .en_rise(en_rise), .expire_evt(expire_evt),
  .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/test_tick_watchdog.sv
`timescale 1ns/1ps
module test_tick_watchdog;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_LD = 12'h000, A_VAL = 12'h004, A_CTL = 12'h008,
                            A_ACK = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                            A_KEY = 12'hC00, A_BAD = 12'h020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prd [2];
  logic rdy [2], err [2], irq [2], rrq [2];

  int tests = 0, fails = 0, cyc = 0, tick_div = 1, tick_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_watchdog #(.DATA_W(DW), .ADDR_W(AW), .STICKY_EN(1'b0)) i_tick_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prd[0]),
    .pready(rdy[0]), .pslverr(err[0]), .irq_o(irq[0]), .rst_req_o(rrq[0]));

  tick_watchdog #(.DATA_W(DW), .ADDR_W(AW), .STICKY_EN(1'b1)) i_sticky (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prd[1]),
    .pready(rdy[1]), .pslverr(err[1]), .irq_o(irq[1]), .rst_req_o(rrq[1]));

  // Reference model: index 0 plain, index 1 sticky
  logic [31:0] m_load [2], m_val [2];
  bit m_ris [2], m_en [2], m_ren [2], m_lock [2], m_rp [2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_load[k] = 32'hFFFF_FFFF; m_val[k] = 32'hFFFF_FFFF;
        m_ris[k] = 0; m_en[k] = 0; m_ren[k] = 0; m_lock[k] = 0; m_rp[k] = 0;
      end else begin
        bit wr, ok, ldw, clw, ctw, rise, nrp;
        logic [31:0] old_load;
        old_load = m_load[k];
        wr   = psel && penable && pwrite;
        ok   = wr && !m_lock[k] && paddr != A_KEY;
        ldw  = ok && paddr == A_LD;
        clw  = ok && paddr == A_ACK;
        ctw  = ok && paddr == A_CTL && !(k == 1 && m_en[k]);
        rise = ctw && pwdata[0] && !m_en[k];
        nrp  = 0;
        if (ldw) m_val[k] = pwdata;
        else if (clw || rise) m_val[k] = old_load;
        else if (m_en[k] && tick_en) begin
          if (m_val[k] == 0) m_val[k] = old_load;
          else begin
            if (m_val[k] == 1) begin
              if (m_ris[k] && m_ren[k]) nrp = 1;
              m_ris[k] = 1;
            end
            m_val[k] = m_val[k] - 1;
          end
        end
        if (clw) m_ris[k] = 0;
        if (ldw) m_load[k] = pwdata;
        if (ctw) begin m_en[k] = pwdata[0]; m_ren[k] = pwdata[1]; end
        if (wr && paddr == A_KEY) m_lock[k] = (pwdata != 32'h1ACC_E551);
        m_rp[k] = nrp;
      end
    end
  end

  function automatic logic [31:0] m_rd(int k, logic [AW-1:0] a);
    case (a)
      A_LD:  return m_load[k];
      A_VAL: return m_val[k];
      A_CTL: return {30'd0, m_ren[k], m_en[k]};
      A_RAW: return {31'd0, m_ris[k]};
      A_MSK: return {31'd0, m_ris[k] & m_en[k]};
      A_KEY: return {31'd0, m_lock[k]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // tick strobe generator
  always @(negedge clk) begin
    if (!rst_n || tick_div == 0) begin tick_en <= 0; tick_cnt = 0; end
    else begin
      tick_cnt++;
      if (tick_cnt >= tick_div) begin tick_en <= 1; tick_cnt = 0; end
      else tick_en <= 0;
    end
  end

  // per-clock comparison of outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk(k ? "R7 irq sticky" : "R7 irq plain", {31'd0, irq[k]}, {31'd0, m_ris[k] & m_en[k]});
        chk(k ? "R8 rst sticky" : "R8 rst plain", {31'd0, rrq[k]}, {31'd0, m_rp[k]});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic apb_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(string tag, logic [AW-1:0] a);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #2;
    for (int k = 0; k < 2; k++) begin
      chk(tag, prd[k], m_rd(k, a));
      chk("R11 pready", {31'd0, rdy[k]}, 32'd1);
      chk("R11 pslverr", {31'd0, err[k]}, 32'd0);
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    // R1: hard values after reset
    apb_rd("R1 reload", A_LD);  chk("R1 reload abs", prd[0], 32'hFFFF_FFFF);
    apb_rd("R1 count", A_VAL);
    apb_rd("R1 ctrl", A_CTL);
    apb_rd("R1 raw", A_RAW);
    apb_rd("R1 masked", A_MSK);
    apb_rd("R1 key", A_KEY);
    apb_rd("R11 unmapped", A_BAD);
    wait_cyc(20);
    apb_rd("R2 hold while disabled", A_VAL); chk("R2 hold abs", prd[0], 32'hFFFF_FFFF);
    apb_wr(A_LD, 32'd10);
    apb_rd("R3 copy while disabled", A_VAL); chk("R3 copy abs", prd[0], 32'd10);
    wait_cyc(15);
    apb_rd("R2 still held", A_VAL);
    // enable with reset enable: two expiries before acknowledge
    apb_wr(A_CTL, 32'd3);
    apb_rd("R6 reload on rise", A_VAL);
    wait_cyc(4);
    apb_rd("R2 counting", A_VAL);
    for (int i = 0; i < 30; i++) begin
      apb_rd("R4 count trace", A_VAL);
    end
    apb_rd("R4 raw set", A_RAW);
    apb_rd("R7 masked", A_MSK);
    apb_wr(A_ACK, 32'hDEAD_BEEF);
    apb_rd("R5 raw cleared", A_RAW);
    // disable: plain freezes, sticky keeps running
    wait_cyc(5);
    apb_wr(A_CTL, 32'd0);
    apb_rd("R10 ctrl readback", A_CTL);
    apb_rd("R6 frozen a", A_VAL);
    wait_cyc(25);
    apb_rd("R6 frozen b", A_VAL);
    apb_rd("R6 raw frozen", A_RAW);
    apb_rd("R7 masked when off", A_MSK);
    apb_wr(A_CTL, 32'd1);
    apb_rd("R6 rise reload", A_VAL);
    apb_wr(A_LD, 32'd50);
    apb_rd("R3 copy while running", A_VAL);
    // lock
    apb_wr(A_KEY, 32'h0);
    apb_rd("R9 locked read", A_KEY);
    apb_wr(A_LD, 32'd7);
    apb_rd("R9 reload unchanged", A_LD); chk("R9 reload abs", prd[0], 32'd50);
    apb_wr(A_CTL, 32'd0);
    apb_rd("R9 ctrl unchanged", A_CTL);
    apb_wr(A_KEY, 32'h1ACC_E551);
    apb_rd("R9 unlocked read", A_KEY);
    // slower tick rate
    tick_div = 3;
    apb_wr(A_LD, 32'd6);
    for (int i = 0; i < 20; i++) apb_rd("R2 slow tick trace", A_VAL);
    apb_rd("R4 raw slow", A_RAW);
    // reset mid-count
    @(negedge clk); rst_n = 0;
    wait_cyc(2); rst_n = 1;
    apb_rd("R1 reload after reset", A_LD);
    apb_rd("R1 ctrl after reset", A_CTL);
    wait_cyc(20);
    apb_rd("R1 count held after reset", A_VAL); chk("R1 count abs", prd[1], 32'hFFFF_FFFF);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule